// File: doc/BRIEF.md
# Serial Shift Unit with Bit Counter

This block moves data over a three-wire synchronous serial link. A data register that software reads and writes directly holds the word to send and collects the word that arrives. A small down-counter sets how many bits the next transfer moves. Both are advanced by one internal shift clock. Writing a nonzero count starts a transfer. Each bit shifts one position in the register and takes one off the count. When the count lands on zero, the transfer stops and a completion flag goes up.

The register works on its low half or on its full width, and it shifts either most-significant or least-significant bit first. In master mode the block makes the serial clock itself by dividing the system clock, and drives it onto the line. In slave mode it takes the serial clock from the line, passes it through a two-stage synchronizer and acts on the edges it sees. The clock idles low. Incoming data is captured on the rising serial-clock edge, and the register shifts on the falling edge. The outgoing data line therefore changes on the falling edge.

Top module: `serial_shift_unit`

## Requirements
- R1: After synchronous reset, the data register, count and flag read 0, and `sclk_out` is 0.
- R2: With `full_width`=0 and `lsb_first`=0, bits [7:0] form the active field. `sdo` presents bit 7. Each shift moves the field left and inserts the received bit at bit 0. Bits [15:8] are left untouched.
- R3: With `full_width`=0 and `lsb_first`=1, `sdo` presents bit 0. Each shift moves [7:0] right and inserts the received bit at bit 7. Bits [15:8] are left untouched.
- R4: With `full_width`=1, all 16 bits shift. `sdo` presents bit 15 when `lsb_first`=0 and bit 0 when it is 1. The received bit enters at bit 0 or bit 15 respectively.
- R5: `sdi` is sampled on the rising serial-clock edge. The register shifts that sampled bit in on the following falling edge, so `sdo` changes only on falling edges.
- R6: Each falling edge takes exactly one off a nonzero count, and a transfer moves as many bits as were written. While the count is 0, the data register and the count do not change on serial-clock edges.
- R7: The flag is set when a shift takes the count from 1 to 0.
- R8: Writing a count of 0 sets the flag.
- R9: Writing a nonzero count clears the flag when `flag_hold`=0. When `flag_hold`=1, the flag keeps its value.
- R10: A `flag_clr` pulse clears the flag unless a set happens in the same cycle.
- R11: In master mode `sclk_oe`=1. `sclk_out` toggles every HALF_DIV system clocks while the count is nonzero, giving rising edges 2*HALF_DIV cycles apart. It is held at 0 while the count is 0.
- R12: In slave mode `sclk_oe`=0, and shifting follows edges of `sclk_in`.
- R13: A write to the data register or the count takes effect on the next clock and reads back unchanged. The write has priority over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = generate serial clock, 0 = follow `sclk_in` |
| full_width | input | 1 | 1 = 16-bit register, 0 = 8-bit (low half) |
| lsb_first | input | 1 | 1 = least-significant bit first |
| flag_hold | input | 1 | 1 = nonzero count write keeps the flag |
| sr_wr | input | 1 | Data register write strobe |
| sr_wdata | input | DATA_W | Data register write value |
| sr_rdata | output | DATA_W | Data register contents |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| cnt_rdata | output | CNT_W | Current count |
| flag_clr | input | 1 | Flag clear strobe |
| flag | output | 1 | Transfer-complete flag |
| sclk_in | input | 1 | Serial clock from the line (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench runs transfers whose length differs from the active width. An 8-bit field that receives more than eight bits must wrap cleanly while its upper byte stays intact, and a design that shifts the full word in narrow mode corrupts bits [15:8]. It checks the first transmitted bit before any clock edge and the bit order on the line. A design that shifts on the sampling edge loses the first bit or sends the last one twice. The flag tests cover a zero write, a nonzero write with and without hold, and a software clear. It also toggles the serial clock with the count at zero: a design that keeps counting or shifting there wraps the count to 31 or changes the data register.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  // One pulse per serial-clock event, in the system clock domain
  typedef struct packed {
    logic sample;  // rising serial edge: capture sdi
    logic shift;   // falling serial edge: move register, count down
  } ssu_event_t;
endpackage

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master,
  input  logic                active,
  input  logic                sclk_in,
  output logic                sclk_out,
  output ssu_pkg::ssu_event_t ev
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic [1:0]       sync_q;
  logic             prev_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(HALF_DIV - 1));

  // Master clock divider, parked low whenever there is nothing to move
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!master || !active) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // Slave clock synchronizer and edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sclk_in};
      prev_q <= sync_q[1];
    end
  end

  always_comb begin
    if (master) begin
      ev.sample = active && tick && !sclk_q;
      ev.shift  = active && tick &&  sclk_q;
    end else begin
      ev.sample = active &&  sync_q[1] && !prev_q;
      ev.shift  = active && !sync_q[1] &&  prev_q;
    end
  end

  assign sclk_out = sclk_q;
endmodule

// File: rtl/ssu_shreg.sv
module ssu_shreg #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                full,
  input  logic                lsb,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  ssu_pkg::ssu_event_t ev,
  input  logic                sdi,
  output logic [DATA_W-1:0]   q,
  output logic                sdo
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] nxt;
  logic              rx_q;

  always_comb begin
    nxt = q_r;
    if (full) begin
      nxt = lsb ? {rx_q, q_r[DATA_W-1:1]} : {q_r[DATA_W-2:0], rx_q};
    end else begin
      nxt[HALF-1:0] = lsb ? {rx_q, q_r[HALF-1:1]} : {q_r[HALF-2:0], rx_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r  <= '0;
      rx_q <= 1'b0;
    end else begin
      if (ev.sample) rx_q <= sdi;
      if (wr)             q_r <= wdata;
      else if (ev.shift)  q_r <= nxt;
    end
  end

  assign q   = q_r;
  assign sdo = lsb ? q_r[0] : (full ? q_r[DATA_W-1] : q_r[HALF-1]);
endmodule

// File: rtl/ssu_bitcnt.sv
module ssu_bitcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             hold,
  input  logic             clr,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             set_f;
  logic             clr_f;

  assign set_f = (wr && (wdata == '0)) ||
                 (!wr && dec && (cnt_q == CNT_W'(1)));
  assign clr_f = (wr && (wdata != '0) && !hold) || clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr)                         cnt_q <= wdata;
      else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      if (set_f)      flag_q <= 1'b1;
      else if (clr_f) flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 5,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_master,
  input  logic              full_width,
  input  logic              lsb_first,
  input  logic              flag_hold,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  output logic [DATA_W-1:0] sr_rdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  input  logic              flag_clr,
  output logic              flag,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo
);
  ssu_pkg::ssu_event_t ev;
  logic                active;

  assign active  = (cnt_rdata != '0);
  assign sclk_oe = mode_master;

  ssu_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .master(mode_master), .active(active),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .ev(ev)
  );

  ssu_shreg #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst(rst), .full(full_width), .lsb(lsb_first),
    .wr(sr_wr), .wdata(sr_wdata), .ev(ev), .sdi(sdi),
    .q(sr_rdata), .sdo(sdo)
  );

  ssu_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(cnt_wdata),
    .hold(flag_hold), .clr(flag_clr), .dec(ev.shift),
    .cnt(cnt_rdata), .flag(flag)
  );
endmodule

// File: rtl/serial_shift_unit_chk.sv
module serial_shift_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_master,
  input logic              flag_hold,
  input logic              sr_wr,
  input logic [DATA_W-1:0] sr_rdata,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic [CNT_W-1:0]  cnt_rdata,
  input logic              flag_clr,
  input logic              flag,
  input logic              sclk_out
);
  assert_zero_write_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cnt_wdata == '0) |=> flag);

  assert_autoclear_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cnt_wdata != '0 && !flag_hold) |=> !flag);

  assert_hold_keeps_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cnt_wdata != '0 && flag_hold && !flag_clr && flag) |=> flag);

  assert_flag_rise_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (cnt_rdata == '0));

  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_master && cnt_rdata == '0 && !cnt_wr) |=> !sclk_out);

  assert_no_shift_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_rdata == '0 && !sr_wr && !cnt_wr) |=> $stable(sr_rdata));

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && cnt_rdata != '0) |=>
      (cnt_rdata == $past(cnt_rdata) || cnt_rdata == $past(cnt_rdata) - 1'b1));
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .mode_master(mode_master), .flag_hold(flag_hold),
  .sr_wr(sr_wr), .sr_rdata(sr_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cnt_rdata(cnt_rdata), .flag_clr(flag_clr), .flag(flag), .sclk_out(sclk_out)
);

// File: tb/test_serial_shift_unit.sv
`timescale 1ns/1ps
module test_serial_shift_unit;
  localparam int DW = 16;
  localparam int CW = 5;
  localparam int HD = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_master = 1'b1, full_width = 1'b0, lsb_first = 1'b0, flag_hold = 1'b0;
  logic          sr_wr = 1'b0, cnt_wr = 1'b0, flag_clr = 1'b0;
  logic [DW-1:0] sr_wdata = '0;
  logic [DW-1:0] sr_rdata;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] cnt_rdata;
  logic          flag, sclk_out, sclk_oe, sdo;
  logic          sclk_in = 1'b0, sdi = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  serial_shift_unit #(.DATA_W(DW), .CNT_W(CW), .HALF_DIV(HD)) i_serial_shift_unit (
    .clk(clk), .rst(rst), .mode_master(mode_master), .full_width(full_width),
    .lsb_first(lsb_first), .flag_hold(flag_hold), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .flag_clr(flag_clr), .flag(flag), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference: returns {transmitted bits in time order, final register}
  function automatic logic [31:0] model(input logic w16, input logic lsb,
                                        input logic [15:0] init, input logic [15:0] rx, input int n);
    logic [15:0] s = init;
    logic [15:0] tx = '0;
    for (int i = 0; i < n; i++) begin
      tx[i] = lsb ? s[0] : (w16 ? s[15] : s[7]);
      if (w16) s = lsb ? {rx[i], s[15:1]} : {s[14:0], rx[i]};
      else     s[7:0] = lsb ? {rx[i], s[7:1]} : {s[6:0], rx[i]};
    end
    return {tx, s};
  endfunction

  function automatic logic [15:0] nmask(input int n);
    logic [16:0] m = (17'd1 << n) - 17'd1;
    return m[15:0];
  endfunction

  task automatic wr_sr(input logic [15:0] v);
    @(negedge clk); sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [4:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic master_xfer(input string req, input logic w16, input logic lsb,
                             input logic [15:0] init, input logic [15:0] rx, input int n);
    logic [15:0] tx = '0;
    logic [31:0] e;
    logic        prev;
    int rises = 0, falls = 0, cyc = 0, last = 0, badp = 0;
    @(negedge clk); mode_master = 1'b1; full_width = w16; lsb_first = lsb; flag_hold = 1'b0;
    wr_sr(init);
    sdi = rx[0];
    wr_cnt(5'(n));
    prev = sclk_out;
    while (falls < n && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (sclk_out && !prev) begin
        if (rises < 16) tx[rises] = sdo;
        if (rises > 0 && (cyc - last) != 2 * HD) badp++;
        last = cyc; rises++;
      end else if (!sclk_out && prev) begin
        falls++;
        sdi = (falls < 16) ? rx[falls] : 1'b0;
      end
      prev = sclk_out;
    end
    repeat (2) @(negedge clk);
    e = model(w16, lsb, init, rx, n);
    chk({req, " register"}, {16'd0, sr_rdata}, {16'd0, e[15:0]});
    chk({req, " sdo order R5"}, {16'd0, tx & nmask(n)}, {16'd0, e[31:16] & nmask(n)});
    chk("R6 bit count", rises, n);
    chk("R7 flag at end", {31'd0, flag}, 32'd1);
    chk("R11 half period", badp, 0);
  endtask

  task automatic slave_xfer(input string req, input logic w16, input logic lsb,
                            input logic [15:0] init, input logic [15:0] rx, input int n);
    logic [15:0] tx = '0;
    logic [31:0] e;
    @(negedge clk); mode_master = 1'b0; full_width = w16; lsb_first = lsb; flag_hold = 1'b0;
    wr_sr(init);
    wr_cnt(5'(n));
    chk("R12 oe low", {31'd0, sclk_oe}, 32'd0);
    for (int i = 0; i < n; i++) begin
      sdi = rx[i];
      repeat (4) @(negedge clk);
      tx[i] = sdo;
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (5) @(negedge clk);
    e = model(w16, lsb, init, rx, n);
    chk({req, " register R12"}, {16'd0, sr_rdata}, {16'd0, e[15:0]});
    chk({req, " sdo order R12"}, {16'd0, tx & nmask(n)}, {16'd0, e[31:16] & nmask(n)});
    chk("R7 slave flag", {31'd0, flag}, 32'd1);
    chk("R6 slave count zero", {27'd0, cnt_rdata}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    int bad;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 register", {16'd0, sr_rdata}, 0);
    chk("R1 count", {27'd0, cnt_rdata}, 0);
    chk("R1 flag", {31'd0, flag}, 0);
    chk("R1 sclk", {31'd0, sclk_out}, 0);
    chk("R11 oe high", {31'd0, sclk_oe}, 1);

    // R13 direct access
    wr_sr(16'hA55A);
    chk("R13 register readback", {16'd0, sr_rdata}, 32'hA55A);

    // Directed master transfers
    master_xfer("R2 msb8",  1'b0, 1'b0, 16'h3C96, 16'h00B1, 8);
    master_xfer("R3 lsb8",  1'b0, 1'b1, 16'hF00D, 16'h0036, 8);
    master_xfer("R4 msb16", 1'b1, 1'b0, 16'h8421, 16'h5AC3, 16);
    master_xfer("R4 lsb16", 1'b1, 1'b1, 16'h1248, 16'hE71B, 16);
    master_xfer("R2 wrap8", 1'b0, 1'b0, 16'hBEEF, 16'h9A5C, 12);

    // R6/R11: idle after transfer, nothing moves
    keep = sr_rdata; bad = 0;
    repeat (20) begin @(negedge clk); if (sclk_out) bad++; end
    chk("R11 idle low", bad, 0);
    chk("R6 idle register", {16'd0, sr_rdata}, {16'd0, keep});

    // Slave transfers
    slave_xfer("R2 slave msb8",  1'b0, 1'b0, 16'h7E81, 16'h0069, 8);
    slave_xfer("R4 slave lsb16", 1'b1, 1'b1, 16'hC3A5, 16'h2D4B, 16);

    // R6: slave edges ignored while count is zero
    keep = sr_rdata;
    repeat (2) begin
      sdi = ~sdi; repeat (4) @(negedge clk); sclk_in = 1'b1;
      repeat (4) @(negedge clk); sclk_in = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk("R6 slave ignored register", {16'd0, sr_rdata}, {16'd0, keep});
    chk("R6 slave ignored count", {27'd0, cnt_rdata}, 0);

    // Flag control in slave mode with idle clock
    wr_cnt(5'd3);
    chk("R9 autoclear", {31'd0, flag}, 0);
    chk("R13 count readback", {27'd0, cnt_rdata}, 3);
    wr_cnt(5'd0);
    chk("R8 zero write", {31'd0, flag}, 1);
    @(negedge clk); flag_hold = 1'b1;
    wr_cnt(5'd7);
    chk("R9 hold keeps flag", {31'd0, flag}, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R10 software clear", {31'd0, flag}, 0);
    wr_cnt(5'd0);
    chk("R8 zero write again", {31'd0, flag}, 1);
    @(negedge clk); flag_hold = 1'b0;

    // Random master transfers
    for (int k = 0; k < 16; k++) begin
      master_xfer("R4 random", 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                  1 + int'($urandom % 16));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule